// File: doc/BRIEF.md
# Two-step refresh watchdog timer

This block is a 16-bit supervision counter. It does not run after reset. Software starts it, and later keeps it from expiring, with the same two-write sequence. First it writes the arm strobe. Then it writes the confirm strobe before twelve instruction-cycle strobes have passed. A valid sequence loads the counter high byte from a 7-bit reload value and clears the low byte. It also clears the clock divider. Once started, the counter advances every 24 system clocks, or every 384 clocks when the slow divider is selected. Only reset stops it.

When the count reaches the fixed threshold 7FFCh, the block enters its bite state. In that state it drives a reset request and a status flag, which is the value software reads back at the confirm bit position. Both stay active until the counter next changes, either by its next advance or by a refresh. The request therefore lasts far longer than the two clocks the chip's reset logic needs. A reload register holds the divider select and the reload value. Software can read or write it at any time, and it takes effect only at the next refresh.

The controller has three states. OFF means stopped, with the count held at zero. RUN means counting. BITE means the threshold has been reached. The transitions are:
- START: OFF to RUN, on a valid confirm.
- REFRESH: RUN or BITE to RUN, on a valid confirm.
- EXPIRE: RUN to BITE, when the counter advances from 7FFBh.
- MOVE_ON: BITE to RUN, on the next advance.
- Reset returns any state to OFF.

Top module: `wdt_twostep`

## Requirements
- R1: After reset, `count` is 0000h, `running`, `wd_stat` and `rst_req` are 0, and `rel_rdata` is 00h.
- R2: A `confirm_wr` pulse while an arm is pending performs a refresh. An arm is pending when `arm_wr` has pulsed and fewer than 12 `icyc_stb` cycles have followed it. A refresh sets `running` to 1 and loads `count` with {0, `rel_rdata`[6:0], 00h}. Both are visible one clock after the confirm is sampled.
- R3: Once 12 `icyc_stb` cycles have followed the arm, the pending arm is dropped. A later confirm changes neither `count` nor `running`.
- R4: A confirm with no pending arm is ignored. A stopped watchdog stays stopped with `count` at 0000h.
- R5: With reload bit 7 = 0 at the last refresh, `count` rises by one exactly 24 clocks after the refresh edge and every 24 clocks after that.
- R6: With reload bit 7 = 1 at the last refresh, the advance period is 384 clocks.
- R7: Writing the reload register updates `rel_rdata` on the next clock. The write does not change `count`, or the advance period, until the next refresh.
- R8: When `count` becomes 7FFCh, `rst_req` and `wd_stat` go to 1. They stay at 1, for at least two clocks, until `count` next changes. They clear either at the next advance to 7FFDh or at a refresh.
- R9: Once `running` is 1, it stays 1 until reset, whatever strobes arrive.
- R10: While `running` is 0, `count` stays at 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icyc_stb | input | 1 | One pulse per instruction cycle; paces the arm window |
| arm_wr | input | 1 | Write of 1 to the arm bit |
| confirm_wr | input | 1 | Write of 1 to the confirm bit |
| rel_wr | input | 1 | Reload register write strobe |
| rel_wdata | input | 8 | Reload data: bit 7 selects the slow divider, bits 6:0 give the high byte |
| rel_rdata | output | 8 | Reload register readback |
| count | output | 16 | Current counter value |
| running | output | 1 | Watchdog has been started |
| wd_stat | output | 1 | Threshold status, as read at the confirm bit position |
| rst_req | output | 1 | Reset request to the chip |

## Verification
Each result falls due at a fixed point. A refresh, or a reload register write, shows up at the first falling edge after the capturing rising edge. The first advance lands exactly 24 clocks after the refresh edge, or 384 with the slow divider. The bench therefore waits N falling edges from the refresh and checks the count one edge before and one edge at each expected change. It samples the threshold flag the same way around the 7FFCh entry and the 7FFDh exit. All strobes are driven on falling edges, so the window limit is hit exactly at the 11th and 12th instruction strobes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_arm_window.sv
// Holds the pending-arm flag and expires it after WIN instruction strobes.
module wdt_arm_window #(
    parameter int WIN = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    input  logic icyc_stb,
    input  logic consume,
    output logic arm_q
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            cyc_q <= '0;
        end else if (arm_wr) begin
            arm_q <= 1'b1;
            cyc_q <= '0;
        end else if (consume) begin
            arm_q <= 1'b0;
            cyc_q <= '0;
        end else if (arm_q && icyc_stb) begin
            if (cyc_q == LAST) begin
                arm_q <= 1'b0;
                cyc_q <= '0;
            end else begin
                cyc_q <= cyc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_prescale.sv
// Divides the clock by BASE_DIV, or BASE_DIV*EXT_DIV when ext_sel is set.
module wdt_prescale #(
    parameter int BASE_DIV = 24,
    parameter int EXT_DIV  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic ext_sel,
    output logic tick
);
    localparam int LIM_MAX = BASE_DIV * EXT_DIV;
    localparam int PW      = $clog2(LIM_MAX);
    localparam logic [PW-1:0] LIM_SLOW = PW'(LIM_MAX - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(BASE_DIV - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    assign lim  = ext_sel ? LIM_SLOW : LIM_FAST;
    assign tick = en && !clr && (pre_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (clr || !en)       pre_q <= '0;
        else if (pre_q == lim)     pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdt_twostep.sv
module wdt_twostep
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int REL_W    = 8,
    parameter int WIN      = 12,
    parameter int BASE_DIV = 24,
    parameter int EXT_DIV  = 16,
    parameter logic [CNT_W-1:0] THRESH = 16'h7FFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             icyc_stb,
    input  logic             arm_wr,
    input  logic             confirm_wr,
    input  logic             rel_wr,
    input  logic [REL_W-1:0] rel_wdata,
    output logic [REL_W-1:0] rel_rdata,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             wd_stat,
    output logic             rst_req
);
    localparam int LO_W = CNT_W - REL_W;
    localparam logic [CNT_W-1:0] PRE_THRESH = THRESH - 1'b1;

    wd_state_e        state_q, state_d;
    logic             arm_q;
    logic             refresh_go;
    logic             tick;
    logic             ext_q;
    logic [REL_W-1:0] rel_q;
    logic [CNT_W-1:0] count_q;

    assign refresh_go = confirm_wr && arm_q;

    wdt_arm_window #(.WIN(WIN)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_wr   (arm_wr),
        .icyc_stb (icyc_stb),
        .consume  (refresh_go),
        .arm_q    (arm_q)
    );

    wdt_prescale #(.BASE_DIV(BASE_DIV), .EXT_DIV(EXT_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (running),
        .clr     (refresh_go),
        .ext_sel (ext_q),
        .tick    (tick)
    );

    // reload register: software view only, applied at refresh
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rel_q <= '0;
        else if (rel_wr) rel_q <= rel_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ext_q <= 1'b0;
        else if (refresh_go) ext_q <= rel_q[REL_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          count_q <= '0;
        else if (refresh_go) count_q <= {1'b0, rel_q[REL_W-2:0], {LO_W{1'b0}}};
        else if (tick)       count_q <= count_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // transitions: START, REFRESH, EXPIRE, MOVE_ON
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF: begin
                if (refresh_go) state_d = WD_RUN;
            end
            WD_RUN: begin
                if (refresh_go)                          state_d = WD_RUN;
                else if (tick && count_q == PRE_THRESH)  state_d = WD_BITE;
            end
            WD_BITE: begin
                if (refresh_go || tick) state_d = WD_RUN;
            end
            default: state_d = WD_OFF;
        endcase
    end

    // outputs
    always_comb begin
        running   = (state_q != WD_OFF);
        rst_req   = (state_q == WD_BITE);
        wd_stat   = (state_q == WD_BITE);
        count     = count_q;
        rel_rdata = rel_q;
    end
endmodule

// File: rtl/wdt_twostep_chk.sv
module wdt_twostep_chk #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] THRESH = 16'h7FFC
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             rst_req
);
    AST_REQ_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == THRESH)); // R8

    AST_REQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && count == THRESH && $past(count) == THRESH - 1'b1)
        |-> rst_req); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |=> rst_req); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(running) |-> running); // R9

    AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (count == '0)); // R10

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && count != $past(count))
        |-> (count == $past(count) + 1'b1 || count[7:0] == 8'h00)); // R5
endmodule

bind wdt_twostep wdt_twostep_chk #(.CNT_W(CNT_W), .THRESH(THRESH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (count),
    .running (running),
    .rst_req (rst_req)
);

// File: tb/sim_wdt_twostep.sv
`timescale 1ns/1ps
module sim_wdt_twostep;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        icyc_stb = 1'b0, arm_wr = 1'b0, confirm_wr = 1'b0, rel_wr = 1'b0;
    logic [7:0]  rel_wdata = 8'h00;
    logic [7:0]  rel_rdata;
    logic [15:0] count;
    logic        running, wd_stat, rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wdt_twostep u0 (
        .clk(clk), .rst_n(rst_n), .icyc_stb(icyc_stb), .arm_wr(arm_wr),
        .confirm_wr(confirm_wr), .rel_wr(rel_wr), .rel_wdata(rel_wdata),
        .rel_rdata(rel_rdata), .count(count), .running(running),
        .wd_stat(wd_stat), .rst_req(rst_req)
    );

    // {reload, falling edges waited after refresh, expected count}
    localparam int NV = 7;
    localparam logic [39:0] VEC [NV] = '{
        40'h05_0000_0500,
        40'h05_0017_0500,
        40'h05_0018_0501,
        40'h7F_0030_7F02,
        40'h85_017F_0500,
        40'h85_0180_0501,
        40'h00_00F0_000A
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_rel(input logic [7:0] v);
        rel_wdata = v; rel_wr = 1'b1;
        @(negedge clk);
        rel_wr = 1'b0;
    endtask

    task automatic do_arm();
        arm_wr = 1'b1;
        @(negedge clk);
        arm_wr = 1'b0;
    endtask

    task automatic do_confirm();
        confirm_wr = 1'b1;
        @(negedge clk);
        confirm_wr = 1'b0;
    endtask

    task automatic do_icyc(input int n);
        icyc_stb = 1'b1;
        repeat (n) @(negedge clk);
        icyc_stb = 1'b0;
    endtask

    task automatic refresh();
        do_arm();
        do_confirm();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog timeout act=hung exp=finished");
        finish_run();
    end

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        // R1 reset state
        chk("R1 count", 32'(count), 32'h0);
        chk("R1 running", 32'(running), 32'h0);
        chk("R1 rst_req", 32'(rst_req), 32'h0);
        chk("R1 wd_stat", 32'(wd_stat), 32'h0);
        chk("R1 rel_rdata", 32'(rel_rdata), 32'h0);

        // R4 confirm without arm
        do_confirm();
        chk("R4 running", 32'(running), 32'h0);
        waitn(30);
        chk("R10 count idle", 32'(count), 32'h0);

        // R3 window expired before confirm
        write_rel(8'h05);
        chk("R7 readback", 32'(rel_rdata), 32'h05);
        do_arm();
        do_icyc(12);
        do_confirm();
        chk("R3 not started", 32'(running), 32'h0);
        chk("R3 count", 32'(count), 32'h0);

        // R2 confirm on last allowed strobe
        do_arm();
        do_icyc(11);
        do_confirm();
        chk("R2 running", 32'(running), 32'h1);
        chk("R2 count", 32'(count), 32'h0500);

        // table: R5 R6 periods and reload shaping
        for (int i = 0; i < NV; i++) begin
            write_rel(VEC[i][39:32]);
            refresh();
            waitn(int'(VEC[i][31:16]));
            chk($sformatf("R5/R6 vec%0d", i), 32'(count), 32'(VEC[i][15:0]));
        end

        // R7 reload write leaves count and rate alone
        write_rel(8'h20);
        refresh();
        write_rel(8'h85);
        chk("R7 readback new", 32'(rel_rdata), 32'h85);
        chk("R7 count kept", 32'(count), 32'h2000);
        waitn(46);
        chk("R7 rate before", 32'(count), 32'h2001);
        waitn(1);
        chk("R7 rate kept", 32'(count), 32'h2002);

        // R3 while running: expired arm leaves count untouched
        write_rel(8'h20);
        refresh();
        write_rel(8'h10);
        do_arm();
        do_icyc(12);
        do_confirm();
        chk("R3 running no reload", 32'(count), 32'h2000);
        chk("R9 still running", 32'(running), 32'h1);

        // R8 threshold
        write_rel(8'h7F);
        refresh();
        waitn(6047);
        chk("R8 before thresh", 32'({count, rst_req}), 32'({16'h7FFB, 1'b0}));
        waitn(1);
        chk("R8 at thresh", 32'({count, rst_req, wd_stat}), 32'({16'h7FFC, 2'b11}));
        waitn(1);
        chk("R8 held 2nd clock", 32'(rst_req), 32'h1);
        waitn(22);
        chk("R8 held to end", 32'({count, rst_req}), 32'({16'h7FFC, 1'b1}));
        waitn(1);
        chk("R8 cleared on move", 32'({count, rst_req, wd_stat}), 32'({16'h7FFD, 2'b00}));

        // R8 refresh during bite
        refresh();
        waitn(6048);
        chk("R8 bite again", 32'(rst_req), 32'h1);
        refresh();
        chk("R8 refresh clears", 32'({count, rst_req}), 32'({16'h7F00, 1'b0}));

        // R9 only reset stops it; R1 after reset
        do_confirm();
        do_icyc(3);
        chk("R9 strobes no stop", 32'(running), 32'h1);
        rst_n = 1'b0;
        waitn(2);
        rst_n = 1'b1;
        waitn(1);
        chk("R1 rerun reset", 32'({count, running, rst_req, rel_rdata}),
            32'({16'h0, 2'b00, 8'h00}));

        finish_run();
    end
endmodule